// File: doc/BRIEF.md
# Retirement PC Linkage Checker

This block watches a retirement trace port on which a core reports, for each retired instruction, its order index, its own program counter and the program counter it hands to its successor. One order index N is given on a configuration input. The block finds the retirement record for N and the one for N+1 and checks that the chain between them is intact: the successor address that N reports must equal the address that N+1 reports for itself.

The core may retire several instructions per cycle on parallel channels, and it need not retire them in program order. The block therefore keeps whichever member of the pair turns up first, together with a flag that says which member it was. It compares the two when the partner appears. If both members turn up in the same cycle on different channels, they are compared directly. When the pair is complete a done flag rises. A broken chain also raises a sticky error flag. Both flags hold until reset.

Top module: `pc_link_monitor`

## Requirements
- R1: While reset is held and after it is released, with no retirements, `link_done` and `link_err` are 0.
- R2: If N retires in one cycle and N+1 in a later cycle with `ret_pc` of N+1 equal to `ret_next_pc` of N, `link_done` is 1 and `link_err` is 0 from the cycle after N+1 retires. Before that cycle `link_done` is 0.
- R3: If the two addresses of R2 differ, `link_err` rises together with `link_done`. `link_err` is never 1 while `link_done` is 0.
- R4: If N+1 retires before N, the same comparison is made when N arrives, and `link_done`/`link_err` update the cycle after N retires.
- R5: If N and N+1 retire in the same cycle on different channels, they are compared directly, and the result shows the following cycle.
- R6: Records whose valid bit is 0, or whose order index is neither N nor N+1, have no effect on either output or on the later result.
- R7: Only the first record seen for each member counts. A repeated record for a member that was already captured is ignored.
- R8: Once `link_done` is 1, `link_done` and `link_err` keep their values until reset, whatever retires afterwards.
- R9: If several channels carry the same member in one cycle, the lowest-numbered channel (channel 0 in bits [W-1:0] of each packed bus) is used.
- R10: Order indices wrap modulo 2^ORDW. When N is all ones, N+1 is the index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_order | input | ORDW | Order index N of the first instruction of the pair |
| ret_valid | input | NRET | Per-channel retirement valid |
| ret_order | input | NRET*ORDW | Per-channel order index, channel c in bits [c*ORDW +: ORDW] |
| ret_pc | input | NRET*XLEN | Per-channel PC of the retired instruction |
| ret_next_pc | input | NRET*XLEN | Per-channel PC of the following instruction |
| link_done | output | 1 | Both members of the pair have been seen |
| link_err | output | 1 | The PC chain between N and N+1 was broken |

## Verification
The bench drives the pair in forward order, in reversed order and in the same cycle, each once with matching and once with mismatching addresses. A design that assumed program order would either miss the reversed case or compare it against the wrong field. The bench sends unrelated order indices, invalid records, and a second copy of an already captured member. A design that latched these would report a false break or lose the real value. It also checks the wrap of N from all ones to zero, where a design that widened the index would never find N+1. Finally it checks the choice of channel when two channels carry the same member, and that the results stay frozen after completion.

// File: rtl/pc_link_pkg.sv
package pc_link_pkg;

  // How the pair was completed in a given cycle.
  typedef enum logic [1:0] {
    LINK_NONE = 2'd0,
    LINK_FWD  = 2'd1,  // lower index captured earlier, successor arrives now
    LINK_REV  = 2'd2,  // successor captured earlier, lower index arrives now
    LINK_SAME = 2'd3   // both members in one cycle
  } link_kind_e;

  function automatic link_kind_e classify(input logic new_lo, input logic new_hi,
                                          input logic had_lo, input logic had_hi);
    if (new_lo && new_hi)      return LINK_SAME;
    else if (new_hi && had_lo) return LINK_FWD;
    else if (new_lo && had_hi) return LINK_REV;
    else                       return LINK_NONE;
  endfunction

endpackage

// File: rtl/pc_link_chan_match.sv
module pc_link_chan_match #(
  parameter int ORDW = 16
) (
  input  logic            valid,
  input  logic [ORDW-1:0] order,
  input  logic [ORDW-1:0] tgt,
  output logic            is_lo,
  output logic            is_hi
);
  // Successor index, wrapping modulo 2^ORDW.
  function automatic logic [ORDW-1:0] succ(input logic [ORDW-1:0] o);
    return o + {{(ORDW-1){1'b0}}, 1'b1};
  endfunction

  assign is_lo = valid && (order == tgt);
  assign is_hi = valid && (order == succ(tgt));

endmodule

// File: rtl/pc_link_pick.sv
module pc_link_pick #(
  parameter int NRET = 2,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NRET-1:0] hit,
  input  logic [NRET*W-1:0] data,
  output logic            any,
  output logic [NRET-1:0] sel,
  output logic [W-1:0]    val
);
  logic [NRET:0] below;  // below[c]: some channel under c hits

  assign below[0] = 1'b0;

  genvar c;
  generate
    for (c = 0; c < NRET; c++) begin : g_chan
      assign sel[c]     = hit[c] && !below[c];
      assign below[c+1] = below[c] || hit[c];
    end
  endgenerate

  assign any = below[NRET];

  always_comb begin
    val = '0;
    for (int k = 0; k < NRET; k++) begin
      if (sel[k]) val = data[k*W +: W];
    end
  end

  // R9: at most one channel chosen, and one is chosen whenever any hits
  p_one_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (any == (hit != '0)));

endmodule

// File: rtl/pc_link_track.sv
module pc_link_track
  import pc_link_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_lo,
  input  logic [XLEN-1:0] lo_next,
  input  logic            any_hi,
  input  logic [XLEN-1:0] hi_pc,
  output logic            done,
  output logic            err
);
  logic            seen_lo_q, seen_hi_q, done_q, err_q;
  logic [XLEN-1:0] latch_q;

  logic            new_lo, new_hi, finish, mismatch;
  link_kind_e      kind;
  logic [XLEN-1:0] cmp_a, cmp_b;

  function automatic logic pcs_agree(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a == b;
  endfunction

  // Only the first record of each member counts (R7); nothing after done (R8).
  assign new_lo = any_lo && !seen_lo_q && !done_q;
  assign new_hi = any_hi && !seen_hi_q && !done_q;
  assign kind   = classify(new_lo, new_hi, seen_lo_q, seen_hi_q);
  assign finish = (kind != LINK_NONE);

  always_comb begin
    unique case (kind)
      LINK_SAME: begin cmp_a = lo_next; cmp_b = hi_pc;   end
      LINK_FWD:  begin cmp_a = latch_q; cmp_b = hi_pc;   end
      LINK_REV:  begin cmp_a = lo_next; cmp_b = latch_q; end
      default:   begin cmp_a = '0;      cmp_b = '0;      end
    endcase
  end

  assign mismatch = finish && !pcs_agree(cmp_a, cmp_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_lo_q <= 1'b0;
      seen_hi_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      latch_q   <= '0;
    end else if (finish) begin
      done_q    <= 1'b1;
      err_q     <= err_q || mismatch;
      seen_lo_q <= 1'b1;
      seen_hi_q <= 1'b1;
    end else if (new_lo) begin
      seen_lo_q <= 1'b1;
      latch_q   <= lo_next;
    end else if (new_hi) begin
      seen_hi_q <= 1'b1;
      latch_q   <= hi_pc;
    end
  end

  assign done = done_q;
  assign err  = err_q;

  // R7: a captured value is not overwritten while waiting for the partner
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen_lo_q || seen_hi_q) && !done_q) |=> $stable(latch_q));

  // R2: at most one member captured while the pair is still open
  p_single_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> !(seen_lo_q && seen_hi_q));

  // R5: completion needs a member arriving in the preceding cycle
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !any_lo && !any_hi) |=> !done_q);

endmodule

// File: rtl/pc_link_monitor.sv
module pc_link_monitor #(
  parameter int NRET = 2,
  parameter int XLEN = 32,
  parameter int ORDW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ORDW-1:0]      tgt_order,
  input  logic [NRET-1:0]      ret_valid,
  input  logic [NRET*ORDW-1:0] ret_order,
  input  logic [NRET*XLEN-1:0] ret_pc,
  input  logic [NRET*XLEN-1:0] ret_next_pc,
  output logic                 link_done,
  output logic                 link_err
);
  logic [NRET-1:0] hit_lo, hit_hi, sel_lo, sel_hi;
  logic            any_lo, any_hi;
  logic [XLEN-1:0] lo_next, hi_pc;

  genvar c;
  generate
    for (c = 0; c < NRET; c++) begin : g_match
      pc_link_chan_match #(.ORDW(ORDW)) u_match (
        .valid (ret_valid[c]),
        .order (ret_order[c*ORDW +: ORDW]),
        .tgt   (tgt_order),
        .is_lo (hit_lo[c]),
        .is_hi (hit_hi[c])
      );
    end
  endgenerate

  pc_link_pick #(.NRET(NRET), .W(XLEN)) u_pick_lo (
    .clk (clk), .rst_n (rst_n), .hit (hit_lo), .data (ret_next_pc),
    .any (any_lo), .sel (sel_lo), .val (lo_next)
  );

  pc_link_pick #(.NRET(NRET), .W(XLEN)) u_pick_hi (
    .clk (clk), .rst_n (rst_n), .hit (hit_hi), .data (ret_pc),
    .any (any_hi), .sel (sel_hi), .val (hi_pc)
  );

  pc_link_track #(.XLEN(XLEN)) u_track (
    .clk (clk), .rst_n (rst_n),
    .any_lo (any_lo), .lo_next (lo_next),
    .any_hi (any_hi), .hi_pc (hi_pc),
    .done (link_done), .err (link_err)
  );

  // R3: an error is only ever reported on a completed pair
  p_err_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> link_done);

  // R8: completion and error are sticky
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> link_done);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> link_err);

  // R10: N and N+1 are never the same index, so no channel matches both
  p_lo_hi_disjoint_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo & hit_hi) == '0);

endmodule

// File: tb/pc_link_monitor_bench.sv
module pc_link_monitor_bench;
  localparam int NRET = 2;
  localparam int XLEN = 32;
  localparam int ORDW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [ORDW-1:0]      tgt_order;
  logic [NRET-1:0]      ret_valid;
  logic [NRET*ORDW-1:0] ret_order;
  logic [NRET*XLEN-1:0] ret_pc;
  logic [NRET*XLEN-1:0] ret_next_pc;
  logic                 link_done, link_err;

  int checks = 0;
  int failures = 0;

  // scoreboard queues
  bit    exp_done_q[$];
  bit    exp_err_q[$];
  string exp_tag_q[$];

  always #5 clk = ~clk;

  pc_link_monitor #(.NRET(NRET), .XLEN(XLEN), .ORDW(ORDW)) u_pc_link_monitor (
    .clk (clk), .rst_n (rst_n), .tgt_order (tgt_order),
    .ret_valid (ret_valid), .ret_order (ret_order),
    .ret_pc (ret_pc), .ret_next_pc (ret_next_pc),
    .link_done (link_done), .link_err (link_err)
  );

  task automatic expect_push(input bit d, input bit e, input string tag);
    exp_done_q.push_back(d);
    exp_err_q.push_back(e);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item and compares against the outputs
  task automatic monitor_pop();
    bit d, e;
    string t;
    d = exp_done_q.pop_front();
    e = exp_err_q.pop_front();
    t = exp_tag_q.pop_front();
    checks++;
    if (link_done !== d || link_err !== e) begin
      failures++;
      $display("FAIL %s: done/err actual=%b%b expected=%b%b", t, link_done, link_err, d, e);
    end
  endtask

  task automatic expect_now(input bit d, input bit e, input string tag);
    expect_push(d, e, tag);
    monitor_pop();
  endtask

  task automatic idle_inputs();
    ret_valid = '0; ret_order = '0; ret_pc = '0; ret_next_pc = '0;
  endtask

  task automatic set_ch(input int ch, input bit v, input logic [ORDW-1:0] o,
                        input logic [XLEN-1:0] pc, input logic [XLEN-1:0] npc);
    ret_valid[ch]                = v;
    ret_order[ch*ORDW +: ORDW]   = o;
    ret_pc[ch*XLEN +: XLEN]      = pc;
    ret_next_pc[ch*XLEN +: XLEN] = npc;
  endtask

  // inputs set at a negedge are taken at the next posedge; after it the
  // registered outputs are sampled at the following negedge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset(input logic [ORDW-1:0] n);
    @(negedge clk);
    rst_n = 1'b0; tgt_order = n; idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; tgt_order = '0; idle_inputs();
    @(negedge clk);
    expect_now(1'b0, 1'b0, "R1 during reset");

    // R1: idle after reset
    do_reset(16'd10);
    repeat (3) @(negedge clk);
    expect_now(1'b0, 1'b0, "R1 idle after reset");

    // R2: forward order, matching
    do_reset(16'd10);
    set_ch(0, 1, 16'd10, 32'h100, 32'h104); step();
    expect_now(1'b0, 1'b0, "R2 after N only");
    set_ch(1, 1, 16'd11, 32'h104, 32'h108); step();
    expect_now(1'b1, 1'b0, "R2 forward match");

    // R3: forward order, mismatch
    do_reset(16'd10);
    set_ch(0, 1, 16'd10, 32'h100, 32'h104); step();
    set_ch(0, 1, 16'd11, 32'h200, 32'h204); step();
    expect_now(1'b1, 1'b1, "R3 forward mismatch");

    // R4: reversed order, matching then mismatching
    do_reset(16'd20);
    set_ch(1, 1, 16'd21, 32'h300, 32'h304); step();
    expect_now(1'b0, 1'b0, "R4 after N+1 only");
    set_ch(0, 1, 16'd20, 32'h2FC, 32'h300); step();
    expect_now(1'b1, 1'b0, "R4 reversed match");
    do_reset(16'd20);
    set_ch(0, 1, 16'd21, 32'h300, 32'h304); step();
    set_ch(1, 1, 16'd20, 32'h2FC, 32'h400); step();
    expect_now(1'b1, 1'b1, "R4 reversed mismatch");

    // R5: same cycle, different channels
    do_reset(16'd5);
    set_ch(0, 1, 16'd6, 32'h40, 32'h44);
    set_ch(1, 1, 16'd5, 32'h3C, 32'h40); step();
    expect_now(1'b1, 1'b0, "R5 same-cycle match");
    do_reset(16'd5);
    set_ch(0, 1, 16'd5, 32'h3C, 32'h50);
    set_ch(1, 1, 16'd6, 32'h40, 32'h44); step();
    expect_now(1'b1, 1'b1, "R5 same-cycle mismatch");

    // R6: invalid and unrelated records are ignored
    do_reset(16'd30);
    set_ch(0, 0, 16'd30, 32'h0, 32'hDEAD);
    set_ch(1, 1, 16'd32, 32'h500, 32'h504); step();
    set_ch(0, 1, 16'd29, 32'h4F8, 32'h4FC);
    set_ch(1, 0, 16'd31, 32'h999, 32'h0); step();
    expect_now(1'b0, 1'b0, "R6 no effect on outputs");
    set_ch(0, 1, 16'd30, 32'h4FC, 32'h500); step();
    set_ch(1, 1, 16'd31, 32'h500, 32'h504); step();
    expect_now(1'b1, 1'b0, "R6 later pair unaffected");

    // R7: repeated member ignored
    do_reset(16'd40);
    set_ch(0, 1, 16'd40, 32'h600, 32'h604); step();
    set_ch(1, 1, 16'd40, 32'h600, 32'h700); step();
    expect_now(1'b0, 1'b0, "R7 repeat does not complete");
    set_ch(0, 1, 16'd41, 32'h604, 32'h608); step();
    expect_now(1'b1, 1'b0, "R7 first capture used");

    // R8: sticky after completion
    do_reset(16'd50);
    set_ch(0, 1, 16'd50, 32'h800, 32'h804);
    set_ch(1, 1, 16'd51, 32'h804, 32'h808); step();
    set_ch(0, 1, 16'd51, 32'h900, 32'h904); step();
    set_ch(1, 1, 16'd50, 32'h800, 32'hABC); step();
    expect_now(1'b1, 1'b0, "R8 clean result holds");
    do_reset(16'd50);
    set_ch(0, 1, 16'd50, 32'h800, 32'h808);
    set_ch(1, 1, 16'd51, 32'h804, 32'h808); step();
    set_ch(0, 1, 16'd50, 32'h800, 32'h804);
    set_ch(1, 1, 16'd51, 32'h804, 32'h808); step();
    expect_now(1'b1, 1'b1, "R8 error holds");

    // R9: lowest channel wins when both carry N
    do_reset(16'd60);
    set_ch(0, 1, 16'd60, 32'hA00, 32'hA04);
    set_ch(1, 1, 16'd60, 32'hA00, 32'hB00); step();
    set_ch(1, 1, 16'd61, 32'hA04, 32'hA08); step();
    expect_now(1'b1, 1'b0, "R9 channel 0 chosen");

    // R10: wraparound of the order index
    do_reset(16'hFFFF);
    set_ch(1, 1, 16'hFFFF, 32'hC00, 32'hC04); step();
    set_ch(0, 1, 16'h0000, 32'hC04, 32'hC08); step();
    expect_now(1'b1, 1'b0, "R10 wrap match");
    do_reset(16'hFFFF);
    set_ch(0, 1, 16'h0000, 32'hC04, 32'hC08); step();
    set_ch(0, 1, 16'hFFFF, 32'hC00, 32'hC10); step();
    expect_now(1'b1, 1'b1, "R10 wrap reversed mismatch");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule